// File: doc/BRIEF.md
# Retriggerable Delayed Pulse Generator

This block turns each accepted rising edge on an asynchronous trigger line into one output pulse. The pulse starts after a programmable wait and stays high for a programmable number of clock cycles. A typical use is as the enable window of a burst: the high time is set to span exactly three periods of a free-running pulse train, so that three of its pulses pass per trigger.

The wait depends on the trigger's position in the sequence. The first trigger after the block is armed waits for the start-delay value. Every later trigger waits for the gap value instead.

All three timing values are written together with one strobe and are held until the next trigger uses them. A ready flag shows when a new set may be written, which is once the set written before has produced its pulse. Values written between the end of one pulse and the next trigger therefore govern that next pulse.

Top module: `rdp_pulse_gen`

## Requirements
- R1: After reset, `pulse_o` is low and `ready_o` is high.
- R2: The trigger passes two synchroniser flops and an edge detector. With a wait of 0, `pulse_o` is first seen high after the third rising clock edge that follows the trigger going high.
- R3: The first trigger accepted after arming waits `init_dly_i` cycles (as last loaded) beyond the R2 latency before `pulse_o` rises.
- R4: Every later accepted trigger, while the block stays armed, waits `low_time_i` cycles instead, and each such trigger starts a fresh wait-then-high sequence.
- R5: `pulse_o` stays high for `high_time_i` cycles, and a value of 0 gives one cycle.
- R6: Trigger edges that arrive while the block is waiting or high are ignored, so they produce no extra pulse.
- R7: With `arm_i` low, `pulse_o` falls one edge later and triggers are ignored. The first trigger after re-arming uses the start delay again.
- R8: `wr_i` while `ready_o` is high captures all three values and drops `ready_o` on the next edge. `wr_i` while `ready_o` is low is ignored.
- R9: A captured set takes effect at the next accepted trigger. `ready_o` rises on the same edge at which the pulse using that set ends, whether the pulse completes or is cut short by disarming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| arm_i | input | 1 | Enables trigger acceptance; low aborts and returns to idle |
| trig_i | input | 1 | Asynchronous trigger, rising edge active |
| wr_i | input | 1 | Write strobe for the three timing values |
| init_dly_i | input | CNT_W | Wait for the first trigger after arming, in cycles |
| low_time_i | input | CNT_W | Wait for later triggers, in cycles |
| high_time_i | input | CNT_W | Pulse length in cycles (0 counts as 1) |
| ready_o | output | 1 | High when a new timing set may be written |
| pulse_o | output | 1 | Delayed output pulse |

## Verification
A stuck first-trigger flag shows up at the ports as a rise time that is off by the difference between the start delay and the gap, and it appears on the first or second pulse after arming. A counter that loads or reloads wrongly shows up within one pulse as a shifted rising edge or a wrong width. A fault in the write or ready logic shows up when a later pulse has the wrong timing, or when `ready_o` is wrong in the cycle the pulse falls. If the busy lockout is lost, an edge that arrives during a pulse produces an extra pulse a few cycles after the current one ends.

// File: rtl/rdp_pkg.sv
// Package rdp_pkg
// Shared definitions for the retriggerable delayed pulse generator.
// Assumes: it is compiled ahead of every rdp_* module.
package rdp_pkg;

    // Sequencer phases: disarmed, armed and waiting, counting the wait, output high
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_WAIT  = 2'd1,
        S_DELAY = 2'd2,
        S_HIGH  = 2'd3
    } seq_state_t;

endpackage

// File: rtl/rdp_trig_sync.sv
// Module rdp_trig_sync
// Brings an asynchronous trigger into the clock domain through a flop chain
// and emits a one-cycle strobe for each rising edge.
// Assumes: trigger high and low phases each last at least one clock cycle.
module rdp_trig_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic edge_o
);

    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    // Shift the raw trigger through the synchroniser and one history stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN_W-2:0], trig_i};
        end
    end

    // Rising edge: synchronised value high, previous value low
    always_comb begin
        edge_o = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
    end

    // R2: an edge strobe never lasts more than one cycle
    p_edge_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);

endmodule

// File: rtl/rdp_timing_bank.sv
// Module rdp_timing_bank
// Holds the pending and the active timing sets. A write is accepted only while
// ready is high. The pending set replaces the active set at the next accepted
// trigger, and ready returns once the pulse that used it has ended.
// Assumes: accept_i and done_i come from the sequencer, and done_i follows
// each accept_i before the next accept_i.
module rdp_timing_bank #(
    parameter int          CNT_W    = 16,
    parameter logic [CNT_W-1:0] DEF_INIT = 4,
    parameter logic [CNT_W-1:0] DEF_LOW  = 2,
    parameter logic [CNT_W-1:0] DEF_HIGH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] init_i,
    input  logic [CNT_W-1:0] low_i,
    input  logic [CNT_W-1:0] high_i,
    input  logic             accept_i,
    input  logic             done_i,
    output logic             ready_o,
    output logic [CNT_W-1:0] eff_init_o,
    output logic [CNT_W-1:0] eff_low_o,
    output logic [CNT_W-1:0] eff_high_o
);

    logic [CNT_W-1:0] pend_init_q, pend_low_q, pend_high_q;
    logic [CNT_W-1:0] act_init_q,  act_low_q,  act_high_q;
    logic             pend_valid_q;
    logic             in_use_q;
    logic             ready_q;
    logic             wr_ok;

    assign wr_ok = wr_i & ready_q;

    // Capture writes, promote the pending set on accept, and track ready
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_init_q  <= DEF_INIT;
            pend_low_q   <= DEF_LOW;
            pend_high_q  <= DEF_HIGH;
            act_init_q   <= DEF_INIT;
            act_low_q    <= DEF_LOW;
            act_high_q   <= DEF_HIGH;
            pend_valid_q <= 1'b0;
            in_use_q     <= 1'b0;
            ready_q      <= 1'b1;
        end else begin
            if (accept_i) begin
                if (pend_valid_q) begin
                    act_init_q <= pend_init_q;
                    act_low_q  <= pend_low_q;
                    act_high_q <= pend_high_q;
                end
                in_use_q     <= pend_valid_q;
                pend_valid_q <= 1'b0;
            end else if (done_i && in_use_q) begin
                in_use_q <= 1'b0;
                ready_q  <= 1'b1;
            end
            if (wr_ok) begin
                pend_init_q  <= init_i;
                pend_low_q   <= low_i;
                pend_high_q  <= high_i;
                pend_valid_q <= 1'b1;
                ready_q      <= 1'b0;
            end
        end
    end

    // Offer the pending set if one waits, otherwise the active set
    always_comb begin
        eff_init_o = pend_valid_q ? pend_init_q : act_init_q;
        eff_low_o  = pend_valid_q ? pend_low_q  : act_low_q;
        eff_high_o = pend_valid_q ? pend_high_q : act_high_q;
    end

    assign ready_o = ready_q;

    // R8: an accepted write drops ready on the next edge
    p_ready_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i && ready_o |=> !ready_o);

    // R8: a write while not ready leaves the pending values untouched
    p_busy_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i && !ready_o |=> $stable(pend_init_q) && $stable(pend_high_q));

    // R9: the end of a pulse that used a new set raises ready
    p_ready_after_use_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_i && in_use_q && !accept_i |=> ready_o);

endmodule

// File: rtl/rdp_sequencer.sv
// Module rdp_sequencer
// Runs the idle / wait / delay / high sequence. The first accepted edge after
// arming waits the start delay, and later edges wait the gap value. Edges that
// arrive while busy or disarmed are dropped.
// Assumes: edge_i is a single-cycle strobe that is already synchronous.
module rdp_sequencer
    import rdp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic             edge_i,
    input  logic [CNT_W-1:0] init_i,
    input  logic [CNT_W-1:0] low_i,
    input  logic [CNT_W-1:0] high_i,
    output logic             accept_o,
    output logic             done_o,
    output logic             pulse_o
);

    seq_state_t       st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] hold_high_q;
    logic             first_q;
    logic [CNT_W-1:0] delay_sel;
    logic             cnt_last;

    // Pick the wait for this edge and flag the final count
    always_comb begin
        delay_sel = first_q ? init_i : low_i;
        cnt_last  = (cnt_q <= CNT_W'(1));
        accept_o  = arm_i && (st_q == S_WAIT) && edge_i;
    end

    // Phase register, down counter and first-trigger flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= S_IDLE;
            cnt_q       <= '0;
            hold_high_q <= '0;
            first_q     <= 1'b1;
        end else if (!arm_i) begin
            st_q    <= S_IDLE;
            cnt_q   <= '0;
            first_q <= 1'b1;
        end else begin
            case (st_q)
                S_IDLE: st_q <= S_WAIT;
                S_WAIT: begin
                    if (accept_o) begin
                        first_q     <= 1'b0;
                        hold_high_q <= high_i;
                        if (delay_sel == '0) begin
                            st_q  <= S_HIGH;
                            cnt_q <= high_i;
                        end else begin
                            st_q  <= S_DELAY;
                            cnt_q <= delay_sel;
                        end
                    end
                end
                S_DELAY: begin
                    if (cnt_last) begin
                        st_q  <= S_HIGH;
                        cnt_q <= hold_high_q;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                S_HIGH: begin
                    if (cnt_last) st_q <= S_WAIT;
                    else          cnt_q <= cnt_q - CNT_W'(1);
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    // A pulse sequence finishes normally or is cut short by disarm
    always_comb begin
        if (arm_i) done_o = (st_q == S_HIGH) && cnt_last;
        else       done_o = (st_q == S_DELAY) || (st_q == S_HIGH);
    end

    assign pulse_o = (st_q == S_HIGH);

    // R7: disarming forces the output low on the next edge
    p_disarm_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_i |=> !pulse_o);

    // R3 and R4: the last wait count leads straight into the high phase
    p_delay_to_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i && st_q == S_DELAY && cnt_last |=> pulse_o);

    // R6: a busy sequencer stays busy while armed and not on its last count
    p_busy_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i && pulse_o && !cnt_last |=> pulse_o);

    // R4: after an accepted edge the start delay is no longer selected
    p_first_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> !first_q);

endmodule

// File: rtl/rdp_pulse_gen.sv
// Module rdp_pulse_gen
// Top level of the retriggerable delayed pulse generator. It ties together the
// trigger synchroniser, the timing bank and the sequencer.
// Assumes: every input except trig_i is synchronous to clk.
module rdp_pulse_gen #(
    parameter int               CNT_W       = 16,
    parameter int               SYNC_STAGES = 2,
    parameter logic [CNT_W-1:0] DEF_INIT    = 4,
    parameter logic [CNT_W-1:0] DEF_LOW     = 2,
    parameter logic [CNT_W-1:0] DEF_HIGH    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic             trig_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] init_dly_i,
    input  logic [CNT_W-1:0] low_time_i,
    input  logic [CNT_W-1:0] high_time_i,
    output logic             ready_o,
    output logic             pulse_o
);

    logic             trig_edge;
    logic             accept;
    logic             done;
    logic [CNT_W-1:0] eff_init, eff_low, eff_high;

    rdp_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (trig_i),
        .edge_o (trig_edge)
    );

    rdp_timing_bank #(
        .CNT_W    (CNT_W),
        .DEF_INIT (DEF_INIT),
        .DEF_LOW  (DEF_LOW),
        .DEF_HIGH (DEF_HIGH)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (wr_i),
        .init_i     (init_dly_i),
        .low_i      (low_time_i),
        .high_i     (high_time_i),
        .accept_i   (accept),
        .done_i     (done),
        .ready_o    (ready_o),
        .eff_init_o (eff_init),
        .eff_low_o  (eff_low),
        .eff_high_o (eff_high)
    );

    rdp_sequencer #(.CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_i    (arm_i),
        .edge_i   (trig_edge),
        .init_i   (eff_init),
        .low_i    (eff_low),
        .high_i   (eff_high),
        .accept_o (accept),
        .done_o   (done),
        .pulse_o  (pulse_o)
    );

    // R1: the cycle after reset the output is low and writes are allowed
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> !pulse_o && ready_o);

endmodule

// File: tb/rdp_pulse_gen_test.sv
// Scoreboard bench for rdp_pulse_gen: the driver queues the expected rise
// cycle and width of each pulse, and a monitor checks what appears.
module rdp_pulse_gen_test;

    typedef struct {
        int    rise;
        int    width;
        string req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 1'b0;
    logic        trig = 1'b0;
    logic        wr = 1'b0;
    logic [15:0] init_v = '0, low_v = '0, high_v = '0;
    logic        ready, pulse;

    int   cyc = 0;
    int   n_run = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;
    exp_t q[$];

    rdp_pulse_gen uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm_i       (arm),
        .trig_i      (trig),
        .wr_i        (wr),
        .init_dly_i  (init_v),
        .low_time_i  (low_v),
        .high_time_i (high_v),
        .ready_o     (ready),
        .pulse_o     (pulse)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // Monitor: compare each observed pulse with the head of the queue
    int  rise_at = 0;
    bit  prev_p = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (pulse && !prev_p) begin
                rise_at = cyc;
                if (q.size() == 0) check(1'b0, "R6 unexpected pulse", cyc, -1);
            end
            if (!pulse && prev_p && q.size() != 0) begin
                exp_t e;
                e = q.pop_front();
                check(rise_at == e.rise, {e.req, " rise cycle"}, rise_at, e.rise);
                check(cyc - rise_at == e.width, {e.req, " width"}, cyc - rise_at, e.width);
            end
            prev_p = pulse;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_set(input int i, input int l, input int h);
        @(negedge clk);
        wr = 1'b1; init_v = 16'(i); low_v = 16'(l); high_v = 16'(h);
        @(negedge clk);
        wr = 1'b0;
    endtask

    // Raise the trigger for two cycles; queue a pulse if one is expected
    task automatic fire(input bit expect_p, input int dly, input int h, input string req);
        exp_t e;
        @(negedge clk);
        trig = 1'b1;
        if (expect_p) begin
            e.rise = cyc + 3 + dly;
            e.width = (h == 0) ? 1 : h;
            e.req = req;
            q.push_back(e);
        end
        tick(2);
        trig = 1'b0;
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        tick(4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", cyc, 0);
        summary();
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1: reset state
        check(pulse == 1'b0, "R1 pulse low", pulse, 0);
        check(ready == 1'b1, "R1 ready high", ready, 1);

        arm = 1'b1;
        tick(2);
        // R8: an accepted write drops ready
        write_set(5, 2, 6);
        check(ready == 1'b0, "R8 ready low after write", ready, 0);
        // R8: a write while not ready is ignored (shown by the next pulse timing)
        write_set(9, 9, 9);
        check(ready == 1'b0, "R8 ready stays low", ready, 0);

        // R3 and R9: the first trigger uses the start delay from the new set
        fire(1'b1, 5, 6, "R3");
        while (!pulse) @(negedge clk);
        while (pulse) begin
            check(ready == 1'b0, "R9 ready low during pulse", ready, 0);
            @(negedge clk);
        end
        check(ready == 1'b1, "R9 ready at pulse end", ready, 1);
        drain();

        // R4: a later trigger uses the gap; R6: an edge during the sequence is ignored
        fire(1'b1, 2, 6, "R4");
        tick(2);
        fire(1'b0, 0, 0, "R6");
        drain();
        tick(10);
        check(q.size() == 0, "R6 no extra pulse queued", q.size(), 0);

        // R2 and R5: zero gap, zero high time
        write_set(7, 0, 0);
        fire(1'b1, 0, 0, "R2 R5");
        drain();
        check(ready == 1'b1, "R9 ready after zero-wait pulse", ready, 1);

        // R7: disarm cuts the pulse short
        write_set(7, 3, 10);
        begin
            exp_t e;
            @(negedge clk);
            trig = 1'b1;
            e.rise = cyc + 6; e.width = 3; e.req = "R7 cut";
            q.push_back(e);
            tick(2);
            trig = 1'b0;
        end
        while (!pulse) @(negedge clk);
        tick(2);
        arm = 1'b0;
        tick(1);
        check(pulse == 1'b0, "R7 low after disarm", pulse, 0);
        check(ready == 1'b1, "R9 ready after abort", ready, 1);
        drain();
        // R7: triggers while disarmed are ignored
        fire(1'b0, 0, 0, "R7");
        tick(12);
        check(q.size() == 0, "R7 no pulse while disarmed", q.size(), 0);

        // R7 and R3: after re-arming the start delay applies again
        arm = 1'b1;
        tick(2);
        fire(1'b1, 7, 10, "R7 R3 rearm");
        drain();
        fire(1'b1, 3, 10, "R4 after rearm");
        drain();

        check(q.size() == 0, "R4 scoreboard empty", q.size(), 0);
        summary();
    end

endmodule